// File: doc/BRIEF.md
# I2C Target Register Pointer and Indexed Bank Window

This block is the addressing core of an I2C target device. It sits between a byte-level target front end and two storage resources: a register file of single-byte and multi-byte registers, and a separate indexed data bank. The front end reports bus events as one-cycle strobes. These are a start or repeated start, a matched address byte with its direction, a received data byte, a request for a byte to transmit, and a stop. The block turns them into register-file and bank accesses.

The first data byte written after a write-direction address byte sets an 8-bit register pointer. Every later byte, whether written or read, accesses the register at the pointer. After an ordinary register the pointer then moves up by one, so bursts walk through consecutive registers. A small fixed set of multi-byte registers keeps the pointer still, so that a burst streams through one register. The bank is reached through two reserved addresses. One holds the bank index and the other is a data window. Each byte moved through the window touches the bank entry at the current index, and the index then steps forward.

Top module: `regptr_bank_core`

## Requirements
- R1: After a write-direction address byte, the first data byte loads the register pointer (`ptr_o`) and causes no register-file or bank write strobe.
- R2: A byte written or read at an ordinary address is followed by the pointer rising by one; pointer 0xFF is followed by 0x00.
- R3: A byte written or read at any of the multi-byte registers 0x29, 0x2D, 0x4F and 0x7F leaves the pointer unchanged.
- R4: A byte written or read at the index-select address 0x60 or the window address 0x61 leaves the pointer unchanged.
- R5: A byte written to 0x60 sets the bank index when its value is at most BANK_DEPTH-1 (200 by default). A larger value is ignored and leaves the index unchanged. Reading 0x60 returns the index.
- R6: Each byte written or read at 0x61 drives the bank port with the current index (`bk_idx_o`). Writes carry the byte on `bk_wdata_o` and reads return `bk_rdata_i`. The index then rises by one.
- R7: A window access made at index BANK_DEPTH-1 is followed by index 0.
- R8: A repeated start followed by a read-direction address byte leaves the pointer unchanged, so reads continue where the earlier transaction left off. A new write-direction transaction reloads the pointer from its first data byte.
- R9: Writes to addresses marked read-only in RO_MASK, or not marked in IMPL_MASK, raise no register-file write strobe. Writes to implemented writable addresses raise `rf_wr_o` with the pointer on `rf_addr_o` and the byte on `rf_wdata_o`.
- R10: Read data is presented on `rd_data_o` with `rd_valid_o` high in the cycle after `rd_req_i`. It comes from the pointer value before the advance. Implemented addresses return `rf_rdata_i` and unimplemented addresses return 0x00.
- R11: After reset the pointer and the bank index are 0 and all access strobes and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or repeated start seen |
| addr_i | input | 1 | Matched address byte received |
| addr_rd_i | input | 1 | Direction of that address byte, 1 = read |
| wr_i | input | 1 | Data byte received from the controller |
| wdata_i | input | 8 | Received data byte |
| rd_req_i | input | 1 | Front end needs a byte to transmit |
| stop_i | input | 1 | Stop seen |
| rd_data_o | output | 8 | Byte to transmit |
| rd_valid_o | output | 1 | rd_data_o is valid |
| ptr_o | output | 8 | Current register pointer |
| rf_wr_o | output | 1 | Register-file write strobe |
| rf_rd_o | output | 1 | Register-file read strobe |
| rf_addr_o | output | 8 | Register-file address |
| rf_wdata_o | output | 8 | Register-file write data |
| rf_rdata_i | input | 8 | Register-file read data, same cycle |
| bk_wr_o | output | 1 | Bank write strobe |
| bk_rd_o | output | 1 | Bank read strobe |
| bk_idx_o | output | IDXW | Bank entry index |
| bk_wdata_o | output | 8 | Bank write data |
| bk_rdata_i | input | 8 | Bank read data, same cycle |

## Verification
A window access at the last bank index does two things in one clock edge: the pointer hold at 0x61 and the index wrap to zero. A read at an ordinary address also does two things in one edge: it captures the transmit byte and advances the pointer. The bench sets the index to the top entry and reads the window twice. It checks that the first byte is the top entry and the second is entry 0, and that the pointer stays at 0x61 throughout. For every pointer value, the bench checks that each returned byte belongs to the address before the advance while `ptr_o` already shows the next address.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

    localparam logic [7:0] SEL_ADDR = 8'h60;
    localparam logic [7:0] WIN_ADDR = 8'h61;

    localparam int N_MB = 4;
    localparam logic [N_MB-1:0][7:0] MB_ADDRS = {8'h7F, 8'h4F, 8'h2D, 8'h29};

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_RF,
        TGT_SEL,
        TGT_WIN
    } tgt_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] addr;
        logic [7:0] data;
    } acc_t;

    function automatic logic holds_ptr(input logic [7:0] a);
        logic h;
        h = (a == SEL_ADDR) || (a == WIN_ADDR);
        for (int i = 0; i < N_MB; i++) begin
            if (a == MB_ADDRS[i]) h = 1'b1;
        end
        return h;
    endfunction

    function automatic tgt_e classify(input logic [7:0] a, input logic [255:0] impl);
        tgt_e t;
        if (a == SEL_ADDR)      t = TGT_SEL;
        else if (a == WIN_ADDR) t = TGT_WIN;
        else if (impl[a])       t = TGT_RF;
        else                    t = TGT_NONE;
        return t;
    endfunction

endpackage

// File: rtl/regptr_seq.sv
module regptr_seq
    import regptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       addr_i,
    input  logic       addr_rd_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    input  logic       rd_req_i,
    input  logic       stop_i,
    input  logic       advance_i,
    output logic [7:0] ptr_o,
    output acc_t       acc_o
);

    logic [7:0] ptr_q;
    logic       first_q;

    always_comb begin
        acc_o.wr   = wr_i & ~first_q;
        acc_o.rd   = rd_req_i & ~wr_i;
        acc_o.addr = ptr_q;
        acc_o.data = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= 8'h00;
            first_q <= 1'b0;
        end else begin
            if (start_i || stop_i) begin
                first_q <= 1'b0;
            end else if (addr_i) begin
                first_q <= ~addr_rd_i;
            end else if (wr_i && first_q) begin
                ptr_q   <= wdata_i;
                first_q <= 1'b0;
            end else if (advance_i) begin
                ptr_q <= ptr_q + 8'd1;
            end
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/regptr_bank_idx.sv
module regptr_bank_idx #(
    parameter int BANK_DEPTH = 201,
    parameter int IDXW       = $clog2(BANK_DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_i,
    input  logic            load_i,
    input  logic [7:0]      load_val_i,
    output logic [IDXW-1:0] idx_o
);

    localparam int IDX_MAX = BANK_DEPTH - 1;

    logic [IDXW-1:0] idx_q;
    logic            at_top;
    logic            load_ok;

    assign at_top  = (int'(idx_q) == IDX_MAX);
    assign load_ok = (int'(load_val_i) <= IDX_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (load_i && load_ok) begin
            idx_q <= IDXW'(load_val_i);
        end else if (step_i) begin
            idx_q <= at_top ? '0 : idx_q + 1'b1;
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/regptr_route.sv
module regptr_route
    import regptr_pkg::*;
#(
    parameter logic [255:0] IMPL_MASK = {128'h0, {128{1'b1}}},
    parameter logic [255:0] RO_MASK   = 256'hFF00,
    parameter int           IDXW      = 8
) (
    input  acc_t            acc_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic [7:0]      rf_rdata_i,
    input  logic [7:0]      bk_rdata_i,
    output logic            rf_wr_o,
    output logic            rf_rd_o,
    output logic [7:0]      rf_addr_o,
    output logic [7:0]      rf_wdata_o,
    output logic            bk_wr_o,
    output logic            bk_rd_o,
    output logic [7:0]      bk_wdata_o,
    output logic            advance_o,
    output logic            step_o,
    output logic            load_o,
    output logic [7:0]      rd_byte_o
);

    tgt_e tgt;
    logic any;

    assign tgt = classify(acc_i.addr, IMPL_MASK);
    assign any = acc_i.wr | acc_i.rd;

    always_comb begin
        rf_addr_o  = acc_i.addr;
        rf_wdata_o = acc_i.data;
        bk_wdata_o = acc_i.data;
        rf_wr_o    = acc_i.wr & (tgt == TGT_RF) & ~RO_MASK[acc_i.addr];
        rf_rd_o    = acc_i.rd & (tgt == TGT_RF);
        bk_wr_o    = acc_i.wr & (tgt == TGT_WIN);
        bk_rd_o    = acc_i.rd & (tgt == TGT_WIN);
        load_o     = acc_i.wr & (tgt == TGT_SEL);
        step_o     = any & (tgt == TGT_WIN);
        advance_o  = any & ~holds_ptr(acc_i.addr);
        case (tgt)
            TGT_RF:  rd_byte_o = rf_rdata_i;
            TGT_SEL: rd_byte_o = 8'(idx_i);
            TGT_WIN: rd_byte_o = bk_rdata_i;
            default: rd_byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/regptr_bank_core.sv
module regptr_bank_core
    import regptr_pkg::*;
#(
    parameter logic [255:0] IMPL_MASK  = {128'h0, {128{1'b1}}},
    parameter logic [255:0] RO_MASK    = 256'hFF00,
    parameter int           BANK_DEPTH = 201,
    parameter int           IDXW       = $clog2(BANK_DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            addr_i,
    input  logic            addr_rd_i,
    input  logic            wr_i,
    input  logic [7:0]      wdata_i,
    input  logic            rd_req_i,
    input  logic            stop_i,
    output logic [7:0]      rd_data_o,
    output logic            rd_valid_o,
    output logic [7:0]      ptr_o,
    output logic            rf_wr_o,
    output logic            rf_rd_o,
    output logic [7:0]      rf_addr_o,
    output logic [7:0]      rf_wdata_o,
    input  logic [7:0]      rf_rdata_i,
    output logic            bk_wr_o,
    output logic            bk_rd_o,
    output logic [IDXW-1:0] bk_idx_o,
    output logic [7:0]      bk_wdata_o,
    input  logic [7:0]      bk_rdata_i
);

    acc_t       acc;
    logic       advance;
    logic       step;
    logic       load;
    logic [7:0] rd_byte;

    regptr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .addr_i    (addr_i),
        .addr_rd_i (addr_rd_i),
        .wr_i      (wr_i),
        .wdata_i   (wdata_i),
        .rd_req_i  (rd_req_i),
        .stop_i    (stop_i),
        .advance_i (advance),
        .ptr_o     (ptr_o),
        .acc_o     (acc)
    );

    regptr_route #(
        .IMPL_MASK (IMPL_MASK),
        .RO_MASK   (RO_MASK),
        .IDXW      (IDXW)
    ) u_route (
        .acc_i      (acc),
        .idx_i      (bk_idx_o),
        .rf_rdata_i (rf_rdata_i),
        .bk_rdata_i (bk_rdata_i),
        .rf_wr_o    (rf_wr_o),
        .rf_rd_o    (rf_rd_o),
        .rf_addr_o  (rf_addr_o),
        .rf_wdata_o (rf_wdata_o),
        .bk_wr_o    (bk_wr_o),
        .bk_rd_o    (bk_rd_o),
        .bk_wdata_o (bk_wdata_o),
        .advance_o  (advance),
        .step_o     (step),
        .load_o     (load),
        .rd_byte_o  (rd_byte)
    );

    regptr_bank_idx #(
        .BANK_DEPTH (BANK_DEPTH),
        .IDXW       (IDXW)
    ) u_idx (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step),
        .load_i     (load),
        .load_val_i (acc.data),
        .idx_o      (bk_idx_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o  <= 8'h00;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= acc.rd;
            if (acc.rd) rd_data_o <= rd_byte;
        end
    end

endmodule

// File: rtl/regptr_checker.sv
module regptr_checker
    import regptr_pkg::*;
#(
    parameter logic [255:0] RO_MASK = 256'hFF00,
    parameter int           IDXW    = 8,
    parameter int           IDX_MAX = 200
) (
    input logic            clk,
    input logic            rst,
    input logic            addr_i,
    input logic            wr_i,
    input logic            rd_req_i,
    input logic [7:0]      ptr_o,
    input logic            rd_valid_o,
    input logic            rf_wr_o,
    input logic            rf_rd_o,
    input logic [7:0]      rf_addr_o,
    input logic            bk_wr_o,
    input logic            bk_rd_o,
    input logic [IDXW-1:0] bk_idx_o
);

    a_r2_read_advance: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !wr_i && !addr_i && !holds_ptr(ptr_o)) |=> (ptr_o == $past(ptr_o) + 8'd1));

    // R3 and R4: the multi-byte registers and the bank addresses hold the pointer
    a_r3_hold_ptr: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !wr_i && !addr_i && holds_ptr(ptr_o)) |=> $stable(ptr_o));

    a_r6_idx_step: assert property (@(posedge clk) disable iff (rst)
        ((bk_wr_o || bk_rd_o) && int'(bk_idx_o) != IDX_MAX) |=> (bk_idx_o == $past(bk_idx_o) + 1'b1));

    a_r7_idx_wrap: assert property (@(posedge clk) disable iff (rst)
        ((bk_wr_o || bk_rd_o) && int'(bk_idx_o) == IDX_MAX) |=> (bk_idx_o == '0));

    a_r8_addr_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (addr_i && !wr_i && !rd_req_i) |=> $stable(ptr_o));

    a_r9_no_ro_write: assert property (@(posedge clk) disable iff (rst)
        rf_wr_o |-> !RO_MASK[rf_addr_o]);

    a_r10_read_valid: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !wr_i) |=> rd_valid_o);

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_wr_o, rf_rd_o, bk_wr_o, bk_rd_o}));

endmodule

bind regptr_bank_core regptr_checker #(
    .RO_MASK (RO_MASK),
    .IDXW    (IDXW),
    .IDX_MAX (BANK_DEPTH - 1)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_req_i   (rd_req_i),
    .ptr_o      (ptr_o),
    .rd_valid_o (rd_valid_o),
    .rf_wr_o    (rf_wr_o),
    .rf_rd_o    (rf_rd_o),
    .rf_addr_o  (rf_addr_o),
    .bk_wr_o    (bk_wr_o),
    .bk_rd_o    (bk_rd_o),
    .bk_idx_o   (bk_idx_o)
);

// File: tb/tb_regptr_bank_core.sv
module tb_regptr_bank_core;

    localparam int TOP = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 0, addr_i = 0, addr_rd_i = 0, wr_i = 0, rd_req_i = 0, stop_i = 0;
    logic [7:0] wdata_i = 0;
    logic [7:0] rd_data_o, ptr_o, rf_addr_o, rf_wdata_o, rf_rdata_i, bk_wdata_o, bk_rdata_i;
    logic       rd_valid_o, rf_wr_o, rf_rd_o, bk_wr_o, bk_rd_o;
    logic [7:0] bk_idx_o;

    logic [7:0] bank [0:255];
    logic [7:0] mbank [0:255];
    int         midx = 0;
    int         nchk = 0, nfail = 0;
    bit         done = 0;

    logic       s_rfwr, s_rfrd, s_bkwr, s_bkrd;
    logic [7:0] s_rfaddr, s_rfwdata, s_bkidx;

    always #4 clk = ~clk;

    regptr_bank_core dut (.*);

    assign rf_rdata_i = rf_addr_o ^ 8'h5A;
    assign bk_rdata_i = bank[bk_idx_o];
    always @(posedge clk) if (bk_wr_o) bank[bk_idx_o] <= bk_wdata_o;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_hold(input logic [7:0] a);
        return a == 8'h29 || a == 8'h2D || a == 8'h4F || a == 8'h7F || a == 8'h60 || a == 8'h61;
    endfunction

    task automatic snap();
        #1;
        s_rfwr = rf_wr_o; s_rfrd = rf_rd_o; s_bkwr = bk_wr_o; s_bkrd = bk_rd_o;
        s_rfaddr = rf_addr_o; s_rfwdata = rf_wdata_o; s_bkidx = bk_idx_o;
    endtask

    task automatic ev_start();
        @(negedge clk) start_i = 1; @(negedge clk) start_i = 0;
    endtask
    task automatic ev_stop();
        @(negedge clk) stop_i = 1; @(negedge clk) stop_i = 0;
    endtask
    task automatic ev_addr(input bit rd);
        @(negedge clk) addr_i = 1; addr_rd_i = rd; @(negedge clk) addr_i = 0;
    endtask
    task automatic ev_wr(input logic [7:0] d);
        @(negedge clk) wr_i = 1; wdata_i = d; snap(); @(negedge clk) wr_i = 0;
    endtask
    task automatic ev_rd();
        @(negedge clk) rd_req_i = 1; snap(); @(negedge clk) rd_req_i = 0;
    endtask

    // open a write transaction and load the pointer
    task automatic set_ptr(input logic [7:0] p);
        ev_start(); ev_addr(0); ev_wr(p);
        chk(!s_rfwr && !s_bkwr, "R1 first byte strobe", {s_rfwr, s_bkwr}, 0);
        chk(ptr_o == p, "R1 pointer load", ptr_o, p);
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] p);
        if (p == 8'h60) return 8'(midx);
        if (p == 8'h61) return mbank[midx];
        if (p < 8'h80)  return p ^ 8'h5A;
        return 8'h00;
    endfunction

    task automatic model_access(input logic [7:0] p, input bit wr, input logic [7:0] d);
        if (p == 8'h60 && wr && int'(d) <= TOP) midx = int'(d);
        if (p == 8'h61) begin
            if (wr) mbank[midx] = d;
            midx = (midx == TOP) ? 0 : midx + 1;
        end
    endtask

    task automatic read_chk(input string req);
        logic [7:0] p, e;
        p = ptr_o;
        e = exp_read(p);
        ev_rd();
        chk(rd_valid_o && rd_data_o == e, {req, " R10 read data"}, rd_data_o, e);
        model_access(p, 0, 0);
        chk(ptr_o == (is_hold(p) ? p : p + 8'd1), {req, " R2/R3/R4 pointer after read"}, ptr_o, is_hold(p) ? p : p + 8'd1);
        chk(int'(bk_idx_o) == midx, {req, " R6 index"}, bk_idx_o, midx);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bank[i] = 8'(i) ^ 8'hA5;
            mbank[i] = 8'(i) ^ 8'hA5;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R11 reset state
        chk(ptr_o == 0, "R11 pointer", ptr_o, 0);
        chk(bk_idx_o == 0, "R11 index", bk_idx_o, 0);
        chk({rf_wr_o, rf_rd_o, bk_wr_o, bk_rd_o, rd_valid_o} == 0, "R11 strobes",
            {rf_wr_o, rf_rd_o, bk_wr_o, bk_rd_o, rd_valid_o}, 0);

        // read sweep over every pointer value, reached through repeated start (R8)
        for (int p = 0; p < 256; p++) begin
            set_ptr(8'(p));
            ev_start(); ev_addr(1);
            chk(ptr_o == 8'(p), "R8 read address keeps pointer", ptr_o, p);
            read_chk("sweep");
            ev_stop();
        end

        // write sweep: one data byte after the pointer byte
        for (int p = 0; p < 256; p++) begin
            logic [7:0] d;
            logic       ewr;
            d = 8'(p) ^ 8'h3C;
            set_ptr(8'(p));
            ewr = (p < 128) && !(p >= 8 && p <= 15) && p != 8'h60 && p != 8'h61;
            ev_wr(d);
            chk(s_rfwr == ewr, "R9 write strobe", s_rfwr, ewr);
            if (ewr) chk(s_rfaddr == 8'(p) && s_rfwdata == d, "R9 write address/data", s_rfaddr, p);
            if (p == 8'h61) chk(s_bkwr && s_bkidx == 8'(midx) && dut.bk_wdata_o == d, "R6 window write", s_bkidx, midx);
            model_access(8'(p), 1, d);
            chk(ptr_o == (is_hold(8'(p)) ? 8'(p) : 8'(p + 1)), "R2/R3/R4 pointer after write", ptr_o, p);
            chk(int'(bk_idx_o) == midx, "R5/R6 index after write", bk_idx_o, midx);
            ev_stop();
        end

        // R2 wrap on a write burst crossing 0xFF
        set_ptr(8'hFE);
        ev_wr(8'h11); chk(!s_rfwr, "R9 unimplemented write", s_rfwr, 0);
        ev_wr(8'h22); chk(ptr_o == 8'h00, "R2 wrap to 0x00", ptr_o, 0);
        ev_wr(8'h33); chk(s_rfwr && s_rfaddr == 8'h00, "R2 write after wrap", s_rfaddr, 0);
        chk(ptr_o == 8'h01, "R2 pointer after wrap", ptr_o, 1);
        ev_stop();

        // R5 index load at top, R7 wrap through window reads
        set_ptr(8'h60); ev_wr(8'(TOP)); model_access(8'h60, 1, 8'(TOP));
        chk(int'(bk_idx_o) == TOP, "R5 index load", bk_idx_o, TOP);
        ev_wr(8'(TOP + 1)); model_access(8'h60, 1, 8'(TOP + 1));
        chk(int'(bk_idx_o) == TOP, "R5 oversize index ignored", bk_idx_o, TOP);
        ev_rd(); chk(rd_data_o == 8'(TOP), "R5 index readback", rd_data_o, TOP);
        ev_stop();
        set_ptr(8'h61); ev_start(); ev_addr(1);
        read_chk("R7 top entry");
        chk(bk_idx_o == 0, "R7 index wrapped", bk_idx_o, 0);
        read_chk("R7 entry zero");
        read_chk("R6 entry one");
        ev_stop();

        // R3 multi-byte burst holds
        set_ptr(8'h2D); ev_start(); ev_addr(1);
        for (int k = 0; k < 3; k++) read_chk("R3 burst");
        ev_stop();

        // R8 resume after repeated start, then reload by a new write transaction
        set_ptr(8'h10); ev_start(); ev_addr(1); read_chk("R8 first");
        ev_start(); ev_addr(1); read_chk("R8 resumed");
        chk(ptr_o == 8'h12, "R8 resumed pointer", ptr_o, 8'h12);
        ev_stop();
        set_ptr(8'h40);
        chk(ptr_o == 8'h40, "R8 reload", ptr_o, 8'h40);
        ev_stop();

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule